// File: doc/BRIEF.md
# Bus-Start-Refreshed Watchdog Supervisor

This block is a supervisory watchdog for a device that sits on a two-wire serial bus. The bus master keeps the supervisor alive by issuing a START condition, which is SDA falling while SCL is high. No dedicated kick pin is needed. Each START restores the countdown to its full length. If the countdown runs out first, the block drives an active-low reset pulse of fixed length. START events that land inside that pulse are ignored.

A two-bit select input chooses one of three timeout lengths, or turns the watchdog off. An external low-voltage flag forces and holds the same reset. While that flag is present, the block also raises a strobe that tells the serial logic to abandon its current transfer. STOP conditions are detected and reported as a one-cycle strobe so that the serial logic can drop back to standby, but they do not feed the watchdog. All time is counted in units of a 1 ms tick-enable input.

Top module: `bus_start_watchdog`

## Requirements
- R1: A START (synchronized SDA going 1 to 0 while synchronized SCL is 1 before and after) reloads the watchdog countdown to the full period of the current select value.
- R2: Select encoding on `wd_sel`: 2'b00 = 1750 ticks, 2'b01 = 750 ticks, 2'b10 = 250 ticks, 2'b11 = watchdog off, so no timeout ever occurs while it stays 2'b11.
- R3: When the countdown expires on a tick with no START in that cycle, `reset_n` goes low on the next clock. It stays low until the 250th tick after that, and rises on the clock that samples that tick.
- R4: A START seen while `reset_n` is low neither refreshes the countdown nor shortens or lengthens the pulse.
- R5: While `lowv` is 1, `reset_n` is low from the next clock onward. After `lowv` returns to 0, `reset_n` rises on the clock of the 250th tick.
- R6: `abort_o` equals `lowv` delayed by one clock.
- R7: A STOP (SDA going 0 to 1 while SCL is 1 before and after) produces `stop_o` high for exactly one clock and does not refresh the watchdog.
- R8: SCL and SDA each pass through two synchronizing flops. A bus event acts on the third clock edge after the line change. A change of both lines in the same cycle (SCL rising while SDA falls) is not a START.
- R9: The countdown reloads to the full period at the end of every reset pulse and immediately on any change of `wd_sel`. With `wd_sel` = 2'b11 the countdown does not advance.
- R10: After the asynchronous reset `rst_n` is released, `reset_n` stays low for 250 ticks before normal watchdog operation begins.
- R11: A START that falls in the same cycle as the expiring tick wins: the countdown is refreshed and no reset pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| wd_sel | input | 2 | Timeout select (00/01/10 = 1750/750/250 ticks, 11 = off) |
| lowv | input | 1 | Low-voltage flag from an external comparator, active high |
| tick | input | 1 | One-cycle enable, once per millisecond |
| reset_n | output | 1 | Supervisor reset output, active low |
| abort_o | output | 1 | Abort-communication signal, high while low voltage is present |
| stop_o | output | 1 | One-cycle strobe on each detected STOP |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a START and the tick that would expire the countdown. The second is a START and an active reset pulse. The first pair is provoked by sweeping the gap between two STARTs over several cycles around the 250-tick period, so that one START lands exactly on the expiring tick. The second pair is provoked by sending STARTs during a pulse, both with and without low voltage. A cycle-by-cycle behavioural model in the bench judges every clock: a refresh must win the tie, and a START inside a pulse must leave the pulse length unchanged.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [1:0] SEL_OFF = 2'b11;

  // Full countdown length for a select code; 0 when the watchdog is off.
  function automatic int period_ticks(input logic [1:0] sel, input int p_long,
                                      input int p_mid, input int p_short);
    case (sel)
      2'b00:   return p_long;
      2'b01:   return p_mid;
      2'b10:   return p_short;
      default: return 0;
    endcase
  endfunction

  function automatic int cnt_width(input int max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/wdg_bus_cond.sv
module wdg_bus_cond #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_evt,
  output logic stop_evt
);
  // Stages 0..SYNC-1 synchronize; stage SYNC holds the previous synced value.
  logic [SYNC:0] scl_pipe;
  logic [SYNC:0] sda_pipe;

  genvar g;
  generate
    for (g = 0; g <= SYNC; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_in;
          sda_pipe[g] <= sda_in;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  endgenerate

  logic scl_now, scl_was, sda_now, sda_was, scl_steady_hi;
  assign scl_now       = scl_pipe[SYNC-1];
  assign scl_was       = scl_pipe[SYNC];
  assign sda_now       = sda_pipe[SYNC-1];
  assign sda_was       = sda_pipe[SYNC];
  assign scl_steady_hi = scl_now & scl_was;

  assign start_evt = scl_steady_hi &  sda_was & ~sda_now;
  assign stop_evt  = scl_steady_hi & ~sda_was &  sda_now;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int P_LONG  = 1750,
  parameter int P_MID   = 750,
  parameter int P_SHORT = 250,
  localparam int CW     = cnt_width(P_LONG)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       start_evt,
  input  logic       hold,
  output logic       expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] full;
  logic [1:0]    sel_q;
  logic          sel_chg;
  logic          enabled;
  logic          reload;

  always_comb full = CW'(period_ticks(sel, P_LONG, P_MID, P_SHORT));

  assign sel_chg = (sel != sel_q);
  assign enabled = (sel != SEL_OFF);
  // A START in the expiring cycle refreshes instead of expiring.
  assign expire  = !hold && enabled && !start_evt && !sel_chg && tick && (cnt == CW'(1));
  assign reload  = hold || (start_evt && !hold) || sel_chg || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= SEL_OFF;
    end else begin
      sel_q <= sel;
      if (reload)              cnt <= full;
      else if (enabled && tick) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse
  import wdg_pkg::*;
#(
  parameter int RST_TICKS = 250,
  localparam int RW       = cnt_width(RST_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lowv,
  input  logic expire,
  output logic active
);
  logic [RW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      left   <= RW'(RST_TICKS);
    end else if (lowv) begin
      active <= 1'b1;
      left   <= RW'(RST_TICKS);
    end else if (active) begin
      if (tick) begin
        if (left == RW'(1)) active <= 1'b0;
        else                left   <= left - RW'(1);
      end
    end else if (expire) begin
      active <= 1'b1;
      left   <= RW'(RST_TICKS);
    end
  end
endmodule

// File: rtl/bus_start_watchdog.sv
module bus_start_watchdog #(
  parameter int SYNC      = 2,
  parameter int P_LONG    = 1750,
  parameter int P_MID     = 750,
  parameter int P_SHORT   = 250,
  parameter int RST_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] wd_sel,
  input  logic       lowv,
  input  logic       tick,
  output logic       reset_n,
  output logic       abort_o,
  output logic       stop_o
);
  logic start_evt;
  logic stop_evt;
  logic expire;
  logic pulse_on;

  wdg_bus_cond #(.SYNC(SYNC)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  wdg_timer #(.P_LONG(P_LONG), .P_MID(P_MID), .P_SHORT(P_SHORT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(wd_sel),
    .start_evt(start_evt), .hold(pulse_on), .expire(expire)
  );

  wdg_rst_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lowv(lowv),
    .expire(expire), .active(pulse_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      abort_o <= lowv;
      stop_o  <= stop_evt;
    end
  end

  assign reset_n = ~pulse_on;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       lowv,
  input logic [1:0] wd_sel,
  input logic       reset_n,
  input logic       stop_o,
  input logic       start_evt,
  input logic       expire
);
  a_r3_expire_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !reset_n);

  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n) |-> ($past(tick) && !$past(lowv)));

  a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_n && start_evt && !tick) |=> !reset_n);

  a_r5_lowv_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    lowv |=> !reset_n);

  a_r2_off_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_sel == 2'b11 && $past(wd_sel) == 2'b11) |-> !expire);

  a_r7_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
endmodule

bind bus_start_watchdog wdg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .lowv(lowv), .wd_sel(wd_sel),
  .reset_n(reset_n), .stop_o(stop_o), .start_evt(start_evt), .expire(expire)
);

// File: tb/bus_start_watchdog_test.sv
module bus_start_watchdog_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1;
  logic sda_in = 1'b1;
  logic [1:0] wd_sel = 2'b10;
  logic lowv = 1'b0;
  logic tick = 1'b0;
  logic reset_n, abort_o, stop_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_div = 1;
  string cur_req = "R10";
  bit finished = 0;

  bus_start_watchdog uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .wd_sel(wd_sel),
    .lowv(lowv), .tick(tick), .reset_n(reset_n), .abort_o(abort_o), .stop_o(stop_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    tick <= (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
  end

  // Behavioural reference model
  int q_scl[3], q_sda[3];
  int m_pulse, m_left, m_wd, m_sel_old, m_abort, m_stop;

  function automatic int full_of(input int s);
    if (s == 3) return 0;
    return (s == 2) ? 250 : ((s == 1) ? 750 : 1750);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (q_scl[i]) begin q_scl[i] = 1; q_sda[i] = 1; end
      m_pulse = 1; m_left = 250; m_wd = 0; m_sel_old = 3; m_abort = 0; m_stop = 0;
    end else begin
      int s, st, sp, chg, ex, was_pulse;
      s   = int'(wd_sel);
      st  = (q_scl[1] && q_scl[2] && q_sda[2] && !q_sda[1]) ? 1 : 0;
      sp  = (q_scl[1] && q_scl[2] && !q_sda[2] && q_sda[1]) ? 1 : 0;
      chg = (s != m_sel_old) ? 1 : 0;
      was_pulse = m_pulse;
      ex  = (!was_pulse && s != 3 && !st && !chg && tick && m_wd == 1) ? 1 : 0;
      if (was_pulse || st || chg || ex) m_wd = full_of(s);
      else if (s != 3 && tick) m_wd = m_wd - 1;
      if (lowv) begin m_pulse = 1; m_left = 250; end
      else if (was_pulse) begin
        if (tick) begin
          if (m_left == 1) m_pulse = 0; else m_left = m_left - 1;
        end
      end else if (ex) begin m_pulse = 1; m_left = 250; end
      m_sel_old = s;
      m_abort = lowv ? 1 : 0;
      m_stop  = sp;
      q_scl[2] = q_scl[1]; q_scl[1] = q_scl[0]; q_scl[0] = scl_in ? 1 : 0;
      q_sda[2] = q_sda[1]; q_sda[1] = q_sda[0]; q_sda[0] = sda_in ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(reset_n == !m_pulse, cur_req, "reset_n", int'(reset_n), m_pulse ? 0 : 1);
      chk(abort_o == m_abort, "R6", "abort_o", int'(abort_o), m_abort);
      chk(stop_o == m_stop, "R7", "stop_o", int'(stop_o), m_stop);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_in = 1; sda_in = 1; wait_cyc(3);
    sda_in = 0; wait_cyc(3);
    scl_in = 0; wait_cyc(2);
    sda_in = 1; wait_cyc(2);
    scl_in = 1; wait_cyc(2);
  endtask

  task automatic bus_stop();
    scl_in = 0; sda_in = 0; wait_cyc(3);
    scl_in = 1; wait_cyc(3);
    sda_in = 1; wait_cyc(3);
  endtask

  task automatic both_change();
    scl_in = 0; sda_in = 1; wait_cyc(3);
    scl_in = 1; sda_in = 0; wait_cyc(3);
    scl_in = 0; wait_cyc(2);
    sda_in = 1; wait_cyc(2);
    scl_in = 1; wait_cyc(2);
  endtask

  task automatic wait_release();
    while (!reset_n) wait_cyc(1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    wait_cyc(4);
    chk(reset_n == 0, "R10", "reset_n in reset", int'(reset_n), 0);
    chk(abort_o == 0 && stop_o == 0, "R10", "strobes in reset", int'({abort_o, stop_o}), 0);
    rst_n = 1;
    cur_req = "R10"; wait_cyc(240);
    chk(reset_n == 0, "R10", "still low before 250 ticks", int'(reset_n), 0);
    wait_cyc(20);
    chk(reset_n == 1, "R10", "released after 250 ticks", int'(reset_n), 1);

    cur_req = "R1";
    for (int i = 0; i < 5; i++) begin bus_start(); wait_cyc(150); end
    chk(reset_n == 1, "R1", "refreshed watchdog", int'(reset_n), 1);

    cur_req = "R3"; wait_cyc(600);

    cur_req = "R4";
    while (reset_n) wait_cyc(1);
    for (int i = 0; i < 4; i++) begin bus_start(); wait_cyc(20); end
    wait_cyc(300);

    cur_req = "R9";
    wait_release();
    wd_sel = 2'b01; wait_cyc(400);
    wd_sel = 2'b00; wait_cyc(100);
    cur_req = "R2";
    wd_sel = 2'b11; wait_cyc(2500);
    chk(reset_n == 1, "R2", "disabled never times out", int'(reset_n), 1);
    wd_sel = 2'b10; wait_cyc(300);

    cur_req = "R7";
    wait_release();
    for (int i = 0; i < 6; i++) begin bus_stop(); wait_cyc(80); end
    wait_cyc(300);

    cur_req = "R8";
    wait_release();
    for (int i = 0; i < 6; i++) begin both_change(); wait_cyc(80); end
    wait_cyc(300);

    cur_req = "R11";
    for (int k = 0; k < 9; k++) begin
      wait_release();
      bus_start();
      wait_cyc(234 + k);
      bus_start();
      wait_cyc(20);
    end
    wait_cyc(600);

    cur_req = "R3";
    tick_div = 3;
    wait_release();
    wait_cyc(1700);
    tick_div = 1;

    cur_req = "R5";
    wait_release();
    bus_start();
    lowv = 1; wait_cyc(3);
    chk(abort_o == 1, "R6", "abort during low voltage", int'(abort_o), 1);
    chk(reset_n == 0, "R5", "reset during low voltage", int'(reset_n), 0);
    bus_start(); wait_cyc(40);
    lowv = 0; wait_cyc(2);
    chk(abort_o == 0, "R6", "abort cleared", int'(abort_o), 0);
    wait_cyc(240);
    chk(reset_n == 0, "R5", "held through 250 ticks", int'(reset_n), 0);
    wait_cyc(15);
    chk(reset_n == 1, "R5", "released after 250 ticks", int'(reset_n), 1);
    wait_cyc(50);

    finish_run();
  end
endmodule